// File: doc/BRIEF.md
# Line Buffer Partition Configuration Selector

This block picks the smallest line-buffer memory arrangement that can hold enough lines for a requested vertical filter. A caller presents the widths seen by the luma and chroma channels, the output-rectangle width, a pixel-depth code, an alpha flag, a 4:2:0 flag, the vertical tap counts and the rounded-up vertical scale ratios for both channels. The caller then pulses `start_i`. The block sizes one line of each channel in 72-bit memory words. It then walks the candidate arrangements in a fixed order and, for each one, divides the memory available to each channel by that channel's line size to get a line-partition count. The first arrangement whose partition counts satisfy the tap rule for both channels wins.

All divisions share one multicycle restoring divider. The inputs must stay unchanged from `start_i` until `done_o`. The result code and an error flag are updated in the cycle that `done_o` is high, and they hold until the next result. A force input bypasses the search entirely and returns the largest arrangement.

Top module: `lb_cfg_select`

## Requirements
- R1: After reset, `done_o`, `err_o` and `cfg_o` are all 0.
- R2: Each channel's line size is the smaller of its viewport width and `out_w_i`, with a result of 0 replaced by 1. Luma uses `vp_w_y_i` and chroma uses `vp_w_c_i`.
- R3: `depth_i` selects the bits per component: code 0 gives 10, code 1 gives 8, code 2 gives 6 and code 3 gives 12. A channel's line occupies ceil(line size × bits / 72) words. The alpha line occupies ceil(luma line size / 6) words.
- R4: The memory available to luma / chroma / alpha in each arrangement is: code 1, 816 / 816 / 984; code 2, 1088 / 1088 / 1312; code 3, 4448 / 1904 / 2752; code 0, 2752 for all three.
- R5: A partition count is the memory available divided by the line words, rounded down. With `alpha_en_i` set, the luma count is reduced to the alpha count when that is smaller. Both counts are then capped at 64.
- R6: A channel fits when ratio > 2 and taps ≤ partitions − ratio + 2, or when ratio ≤ 2 and taps ≤ partitions. An arrangement is accepted only if both channels fit.
- R7: The candidates are tried in the order code 1, code 2, code 3 (only when `fmt420_i` is 1), and finally code 0. `cfg_o` reports the first one accepted.
- R8: `force_max_i` set together with `start_i` gives `done_o` on the next cycle, with `cfg_o` = 0 and `err_o` = 0.
- R9: When code 0 is also rejected, the result is `cfg_o` = 0 with `err_o` = 1. Otherwise `err_o` is 0.
- R10: `done_o` is high for exactly one cycle per request. `cfg_o` and `err_o` change only in that cycle and hold until the next result.
- R11: A `start_i` pulse arriving while a search runs is ignored: it produces no extra `done_o` and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| force_max_i | input | 1 | Skip the search and return code 0 |
| fmt420_i | input | 1 | Source is 4:2:0, which enables candidate code 3 |
| alpha_en_i | input | 1 | Alpha plane stored, which may limit the luma partitions |
| depth_i | input | 2 | Pixel-depth code (0:10, 1:8, 2:6, 3:12 bits) |
| vp_w_y_i | input | W_W | Luma viewport width |
| vp_w_c_i | input | W_W | Chroma viewport width |
| out_w_i | input | W_W | Output rectangle width |
| vtaps_y_i | input | TAP_W | Luma vertical taps |
| vtaps_c_i | input | TAP_W | Chroma vertical taps |
| vratio_y_i | input | RAT_W | Luma vertical ratio, rounded up |
| vratio_c_i | input | RAT_W | Chroma vertical ratio, rounded up |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_o | output | 2 | Chosen arrangement code |
| err_o | output | 1 | Code 0 also rejected |

## Verification
The bench builds the block with `W_W` = 11, which gives a 16-bit divider and widths up to 2047. At that size, a 2047-pixel line at 12 bits leaves only 8 partitions in code 0. The error outcome, each arrangement code and the 64-partition cap are therefore all reachable with 4-bit taps and ratios. A sweep covers every depth code, both alpha settings and both format settings, across six width triples and four tap/ratio sets. Every result is compared with the formulas worked out in the bench. Directed cases sit exactly on the tap-rule boundary, exercise the alpha limit, and pulse start in the middle of a search.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;

    localparam int BPC_W        = 4;
    localparam int MEM_W        = 13;
    localparam int WORD_BITS    = 72;
    localparam int ALPHA_PER_WD = 6;
    localparam int PART_CAP     = 64;
    localparam int PART_W       = $clog2(PART_CAP + 1);

    localparam int BANK_L1 = 816;
    localparam int BANK_L2 = 1088;
    localparam int BANK_LX = 848;
    localparam int BANK_A1 = 984;
    localparam int BANK_A2 = 1312;
    localparam int BANK_AX = 456;

    typedef enum logic [1:0] {
        LBC_0 = 2'd0,
        LBC_1 = 2'd1,
        LBC_2 = 2'd2,
        LBC_3 = 2'd3
    } lb_cfg_e;

    typedef enum logic [1:0] {
        CH_Y = 2'd0,
        CH_C = 2'd1,
        CH_A = 2'd2
    } chan_e;

    typedef enum logic [2:0] {
        OP_WY = 3'd0,
        OP_WC = 3'd1,
        OP_WA = 3'd2,
        OP_PY = 3'd3,
        OP_PC = 3'd4,
        OP_PA = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DIV   = 2'd1,
        S_CHECK = 2'd2,
        S_DONE  = 2'd3
    } state_e;

    function automatic logic [BPC_W-1:0] bpc_of(input logic [1:0] code);
        case (code)
            2'd0:    return BPC_W'(10);
            2'd1:    return BPC_W'(8);
            2'd2:    return BPC_W'(6);
            default: return BPC_W'(12);
        endcase
    endfunction

    function automatic logic [MEM_W-1:0] mem_words(input lb_cfg_e c, input chan_e ch);
        case (c)
            LBC_1:
                return (ch == CH_A) ? MEM_W'(BANK_A1) : MEM_W'(BANK_L1);
            LBC_2:
                return (ch == CH_A) ? MEM_W'(BANK_A2) : MEM_W'(BANK_L2);
            LBC_3: begin
                if (ch == CH_Y) return MEM_W'(BANK_L1 + BANK_L2 + 3 * BANK_LX);
                if (ch == CH_C) return MEM_W'(BANK_L1 + BANK_L2);
                return MEM_W'(BANK_A1 + BANK_A2 + BANK_AX);
            end
            default:
                return (ch == CH_A) ? MEM_W'(BANK_A1 + BANK_A2 + BANK_AX)
                                    : MEM_W'(BANK_L1 + BANK_L2 + BANK_LX);
        endcase
    endfunction

    function automatic lb_cfg_e next_cand(input lb_cfg_e c, input logic is420);
        case (c)
            LBC_1:   return LBC_2;
            LBC_2:   return is420 ? LBC_3 : LBC_0;
            default: return LBC_0;
        endcase
    endfunction

endpackage

// File: rtl/lbsel_divider.sv
module lbsel_divider #(
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [NW-1:0] num_i,
    input  logic [NW-1:0] den_i,
    output logic [NW-1:0] quo_o,
    output logic          done_o
);
    localparam int CNT_W = $clog2(NW + 1);

    logic [NW-1:0]    quo_q;
    logic [NW-1:0]    den_q;
    logic [NW:0]      rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             done_q;

    logic [NW:0] shifted;
    logic        take;

    assign shifted = {rem_q[NW-1:0], quo_q[NW-1]};
    assign take    = (shifted >= {1'b0, den_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                quo_q <= num_i;
                den_q <= den_i;
                rem_q <= '0;
                cnt_q <= CNT_W'(NW);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= take ? (shifted - {1'b0, den_q}) : shifted;
                quo_q <= {quo_q[NW-2:0], take};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quo_o  = quo_q;
    assign done_o = done_q;

endmodule

// File: rtl/lbsel_fit.sv
module lbsel_fit #(
    parameter int TAP_W  = 4,
    parameter int RAT_W  = 4,
    parameter int PART_W = 7
) (
    input  logic [TAP_W-1:0]  taps_i,
    input  logic [RAT_W-1:0]  ratio_i,
    input  logic [PART_W-1:0] parts_i,
    output logic              ok_o
);
    localparam int MX1 = (TAP_W > RAT_W) ? TAP_W : RAT_W;
    localparam int MX2 = (MX1 > PART_W) ? MX1 : PART_W;
    localparam int SW  = MX2 + 2;

    logic [SW-1:0] t_w, r_w, p_w;

    assign t_w = SW'(taps_i);
    assign r_w = SW'(ratio_i);
    assign p_w = SW'(parts_i);

    // rearranged so no intermediate goes negative
    assign ok_o = (ratio_i > RAT_W'(2)) ? ((t_w + r_w) <= (p_w + SW'(2)))
                                        : (t_w <= p_w);

endmodule

// File: rtl/lb_cfg_select.sv
module lb_cfg_select
    import lbsel_pkg::*;
#(
    parameter int W_W   = 13,
    parameter int TAP_W = 4,
    parameter int RAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             force_max_i,
    input  logic             fmt420_i,
    input  logic             alpha_en_i,
    input  logic [1:0]       depth_i,
    input  logic [W_W-1:0]   vp_w_y_i,
    input  logic [W_W-1:0]   vp_w_c_i,
    input  logic [W_W-1:0]   out_w_i,
    input  logic [TAP_W-1:0] vtaps_y_i,
    input  logic [TAP_W-1:0] vtaps_c_i,
    input  logic [RAT_W-1:0] vratio_y_i,
    input  logic [RAT_W-1:0] vratio_c_i,
    output logic             done_o,
    output logic [1:0]       cfg_o,
    output logic             err_o
);
    localparam int PRD_W = W_W + BPC_W + 1;
    localparam int DIV_W = (PRD_W > MEM_W) ? PRD_W : MEM_W;
    localparam int NCH   = 2;

    // ---------------- line sizing per channel ----------------
    logic [W_W-1:0]   vp_w    [NCH];
    logic [W_W-1:0]   line_sz [NCH];
    logic [TAP_W-1:0] taps    [NCH];
    logic [RAT_W-1:0] ratio   [NCH];
    logic [PART_W-1:0] parts  [NCH];
    logic [NCH-1:0]   fit_ok;

    assign vp_w[0]  = vp_w_y_i;
    assign vp_w[1]  = vp_w_c_i;
    assign taps[0]  = vtaps_y_i;
    assign taps[1]  = vtaps_c_i;
    assign ratio[0] = vratio_y_i;
    assign ratio[1] = vratio_c_i;

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_line
            logic [W_W-1:0] narrow;
            assign narrow      = (vp_w[ch] < out_w_i) ? vp_w[ch] : out_w_i;
            assign line_sz[ch] = (narrow == '0) ? W_W'(1) : narrow;
        end
    endgenerate

    logic [BPC_W-1:0] bpc;
    assign bpc = bpc_of(depth_i);

    // ---------------- sequencer state ----------------
    state_e         state_q;
    op_e            op_q;
    lb_cfg_e        cand_q;
    logic           go_q;
    logic [DIV_W-1:0] wy_q, wc_q, wa_q;
    logic [DIV_W-1:0] qy_q, qc_q, qa_q;
    lb_cfg_e        cfg_q;
    logic           err_q;

    // ---------------- shared divider ----------------
    logic [DIV_W-1:0] div_num, div_den, div_quo;
    logic             div_done;

    always_comb begin
        div_num = '0;
        div_den = DIV_W'(1);
        case (op_q)
            OP_WY: begin
                div_num = DIV_W'(line_sz[0]) * DIV_W'(bpc) + DIV_W'(WORD_BITS - 1);
                div_den = DIV_W'(WORD_BITS);
            end
            OP_WC: begin
                div_num = DIV_W'(line_sz[1]) * DIV_W'(bpc) + DIV_W'(WORD_BITS - 1);
                div_den = DIV_W'(WORD_BITS);
            end
            OP_WA: begin
                div_num = DIV_W'(line_sz[0]) + DIV_W'(ALPHA_PER_WD - 1);
                div_den = DIV_W'(ALPHA_PER_WD);
            end
            OP_PY: begin
                div_num = DIV_W'(mem_words(cand_q, CH_Y));
                div_den = wy_q;
            end
            OP_PC: begin
                div_num = DIV_W'(mem_words(cand_q, CH_C));
                div_den = wc_q;
            end
            OP_PA: begin
                div_num = DIV_W'(mem_words(cand_q, CH_A));
                div_den = wa_q;
            end
            default: begin
                div_num = '0;
                div_den = DIV_W'(1);
            end
        endcase
    end

    lbsel_divider #(.NW(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .start_i(go_q),
        .num_i  (div_num),
        .den_i  (div_den),
        .quo_o  (div_quo),
        .done_o (div_done)
    );

    // ---------------- partition limiting ----------------
    logic [DIV_W-1:0] py_lim;
    assign py_lim = (alpha_en_i && (qa_q < qy_q)) ? qa_q : qy_q;

    assign parts[0] = (py_lim > DIV_W'(PART_CAP)) ? PART_W'(PART_CAP) : PART_W'(py_lim);
    assign parts[1] = (qc_q   > DIV_W'(PART_CAP)) ? PART_W'(PART_CAP) : PART_W'(qc_q);

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_fit
            lbsel_fit #(
                .TAP_W (TAP_W),
                .RAT_W (RAT_W),
                .PART_W(PART_W)
            ) u_fit (
                .taps_i (taps[ch]),
                .ratio_i(ratio[ch]),
                .parts_i(parts[ch]),
                .ok_o   (fit_ok[ch])
            );
        end
    endgenerate

    // ---------------- control ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            op_q    <= OP_WY;
            cand_q  <= LBC_1;
            go_q    <= 1'b0;
            wy_q    <= DIV_W'(1);
            wc_q    <= DIV_W'(1);
            wa_q    <= DIV_W'(1);
            qy_q    <= '0;
            qc_q    <= '0;
            qa_q    <= '0;
            cfg_q   <= LBC_0;
            err_q   <= 1'b0;
        end else begin
            go_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        if (force_max_i) begin
                            cfg_q   <= LBC_0;
                            err_q   <= 1'b0;
                            state_q <= S_DONE;
                        end else begin
                            cand_q  <= LBC_1;
                            op_q    <= OP_WY;
                            go_q    <= 1'b1;
                            state_q <= S_DIV;
                        end
                    end
                end
                S_DIV: begin
                    if (div_done) begin
                        case (op_q)
                            OP_WY:   wy_q <= div_quo;
                            OP_WC:   wc_q <= div_quo;
                            OP_WA:   wa_q <= div_quo;
                            OP_PY:   qy_q <= div_quo;
                            OP_PC:   qc_q <= div_quo;
                            default: qa_q <= div_quo;
                        endcase
                        if (op_q == OP_PA) begin
                            state_q <= S_CHECK;
                        end else begin
                            op_q <= op_e'(3'(op_q) + 3'd1);
                            go_q <= 1'b1;
                        end
                    end
                end
                S_CHECK: begin
                    if (&fit_ok) begin
                        cfg_q   <= cand_q;
                        err_q   <= 1'b0;
                        state_q <= S_DONE;
                    end else if (cand_q == LBC_0) begin
                        cfg_q   <= LBC_0;
                        err_q   <= 1'b1;
                        state_q <= S_DONE;
                    end else begin
                        cand_q  <= next_cand(cand_q, fmt420_i);
                        op_q    <= OP_PY;
                        go_q    <= 1'b1;
                        state_q <= S_DIV;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign done_o = (state_q == S_DONE);
    assign cfg_o  = cfg_q;
    assign err_o  = err_q;

endmodule

// File: rtl/lb_cfg_select_chk.sv
module lb_cfg_select_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       force_max_i,
    input logic       fmt420_i,
    input logic       done_o,
    input logic [1:0] cfg_o,
    input logic       err_o
);
    logic chk_busy;

    always_ff @(posedge clk) begin
        if (rst)              chk_busy <= 1'b0;
        else if (done_o)      chk_busy <= 1'b0;
        else if (start_i)     chk_busy <= 1'b1;
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(cfg_o) && $stable(err_o)));

    // R9
    err_cfg0_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (cfg_o == 2'd0));

    // R8
    force_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && force_max_i && !chk_busy) |=> (done_o && cfg_o == 2'd0 && !err_o));

    // R7
    cfg3_420_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && cfg_o == 2'd3) |-> fmt420_i);

    // R11
    done_requested_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> chk_busy);

endmodule

bind lb_cfg_select lb_cfg_select_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .force_max_i(force_max_i),
    .fmt420_i   (fmt420_i),
    .done_o     (done_o),
    .cfg_o      (cfg_o),
    .err_o      (err_o)
);

// File: tb/lb_cfg_select_bench.sv
module lb_cfg_select_bench;
    localparam int W_W   = 11;
    localparam int TAP_W = 4;
    localparam int RAT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic             force_max_i = 1'b0;
    logic             fmt420_i = 1'b0;
    logic             alpha_en_i = 1'b0;
    logic [1:0]       depth_i = '0;
    logic [W_W-1:0]   vp_w_y_i = '0;
    logic [W_W-1:0]   vp_w_c_i = '0;
    logic [W_W-1:0]   out_w_i = '0;
    logic [TAP_W-1:0] vtaps_y_i = '0;
    logic [TAP_W-1:0] vtaps_c_i = '0;
    logic [RAT_W-1:0] vratio_y_i = '0;
    logic [RAT_W-1:0] vratio_c_i = '0;
    logic             done_o;
    logic [1:0]       cfg_o;
    logic             err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lb_cfg_select #(.W_W(W_W), .TAP_W(TAP_W), .RAT_W(RAT_W)) u_lb_cfg_select (
        .clk(clk), .rst(rst), .start_i(start_i), .force_max_i(force_max_i),
        .fmt420_i(fmt420_i), .alpha_en_i(alpha_en_i), .depth_i(depth_i),
        .vp_w_y_i(vp_w_y_i), .vp_w_c_i(vp_w_c_i), .out_w_i(out_w_i),
        .vtaps_y_i(vtaps_y_i), .vtaps_c_i(vtaps_c_i),
        .vratio_y_i(vratio_y_i), .vratio_c_i(vratio_c_i),
        .done_o(done_o), .cfg_o(cfg_o), .err_o(err_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit fits(input int t, input int r, input int p);
        if (r > 2) return t <= p - r + 2;
        return t <= p;
    endfunction

    function automatic void model(input int vy, input int vc, input int ow, input int dc,
                                  input bit al, input bit f420, input bit fmax,
                                  input int ty, input int tc, input int ry, input int rc,
                                  output int ecfg, output bit eerr);
        int bpc_t [4];
        int my [4];
        int mc [4];
        int ma [4];
        int order [4];
        int ly, lc, wy, wc, wa, py, pc, pa, c;
        bpc_t = '{10, 8, 6, 12};
        my    = '{2752, 816, 1088, 4448};
        mc    = '{2752, 816, 1088, 1904};
        ma    = '{2752, 984, 1312, 2752};
        order = '{1, 2, 3, 0};
        ecfg = 0;
        eerr = 1'b0;
        if (fmax) return;
        ly = (vy < ow) ? vy : ow;
        lc = (vc < ow) ? vc : ow;
        if (ly == 0) ly = 1;
        if (lc == 0) lc = 1;
        wy = (ly * bpc_t[dc] + 71) / 72;
        wc = (lc * bpc_t[dc] + 71) / 72;
        wa = (ly + 5) / 6;
        for (int k = 0; k < 4; k++) begin
            c = order[k];
            if (c == 3 && !f420) continue;
            py = my[c] / wy;
            pc = mc[c] / wc;
            pa = ma[c] / wa;
            if (al && pa < py) py = pa;
            if (py > 64) py = 64;
            if (pc > 64) pc = 64;
            if (fits(ty, ry, py) && fits(tc, rc, pc)) begin
                ecfg = c;
                return;
            end
        end
        ecfg = 0;
        eerr = 1'b1;
    endfunction

    task automatic run_case(input string tag, input int vy, input int vc, input int ow,
                            input int dc, input bit al, input bit f420, input bit fmax,
                            input int ty, input int tc, input int ry, input int rc,
                            input bit poke_start);
        int ecfg;
        bit eerr;
        int waited;
        model(vy, vc, ow, dc, al, f420, fmax, ty, tc, ry, rc, ecfg, eerr);
        vp_w_y_i    = W_W'(vy);
        vp_w_c_i    = W_W'(vc);
        out_w_i     = W_W'(ow);
        depth_i     = 2'(dc);
        alpha_en_i  = al;
        fmt420_i    = f420;
        force_max_i = fmax;
        vtaps_y_i   = TAP_W'(ty);
        vtaps_c_i   = TAP_W'(tc);
        vratio_y_i  = RAT_W'(ry);
        vratio_c_i  = RAT_W'(rc);
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 3000) begin
            waited++;
            if (poke_start && waited == 4) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        check({tag, " done seen"}, int'(done_o), 1);
        check({tag, " cfg"}, int'(cfg_o), ecfg);
        check({tag, " err"}, int'(err_o), int'(eerr));
        @(negedge clk);
        // R10: one-cycle done
        check("R10 done low after pulse", int'(done_o), 0);
    endtask

    initial begin
        int sw_y [6];
        int sw_c [6];
        int sw_o [6];
        int st_y [4];
        int st_c [4];
        int sr_y [4];
        int sr_c [4];
        int extra_done;
        sw_y = '{0, 100, 2047, 700, 1500, 64};
        sw_c = '{0, 50, 1024, 350, 750, 32};
        sw_o = '{100, 0, 2047, 900, 1400, 2047};
        st_y = '{4, 6, 8, 15};
        st_c = '{2, 6, 4, 12};
        sr_y = '{1, 4, 3, 6};
        sr_c = '{1, 2, 5, 8};

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done at reset", int'(done_o), 0);
        check("R1 cfg at reset", int'(cfg_o), 0);
        check("R1 err at reset", int'(err_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", int'(done_o), 0);

        // R2: zero output width forces line size 1
        run_case("R2 zero width", 500, 500, 0, 3, 1'b0, 1'b0, 1'b0, 15, 15, 1, 1, 1'b0);
        run_case("R2 min of widths", 2047, 40, 300, 3, 1'b0, 1'b0, 1'b0, 15, 12, 6, 8, 1'b0);
        // R3: each depth code with a wide line
        for (int d = 0; d < 4; d++)
            run_case("R3 depth code", 2047, 2047, 2047, d, 1'b0, 1'b0, 1'b0, 6, 6, 1, 1, 1'b0);
        // R4: code 3 memory reachable only with 4:2:0
        run_case("R4 code3 420", 700, 350, 900, 0, 1'b0, 1'b1, 1'b0, 15, 12, 6, 8, 1'b0);
        run_case("R4 no code3 444", 700, 350, 900, 0, 1'b0, 1'b0, 1'b0, 15, 12, 6, 8, 1'b0);
        // R5: alpha limits luma partitions (expects code 2 with alpha, code 1 without)
        run_case("R5 alpha limit", 2047, 100, 2047, 2, 1'b1, 1'b0, 1'b0, 3, 2, 1, 1, 1'b0);
        run_case("R5 alpha off", 2047, 100, 2047, 2, 1'b0, 1'b0, 1'b0, 3, 2, 1, 1, 1'b0);
        run_case("R5 cap 64", 1, 1, 1, 3, 1'b0, 1'b0, 1'b0, 15, 15, 15, 15, 1'b0);
        // R6: tap rule boundary (8 partitions in code 1, ratio 3)
        run_case("R6 boundary pass", 700, 10, 700, 0, 1'b0, 1'b0, 1'b0, 7, 2, 3, 1, 1'b0);
        run_case("R6 boundary fail", 700, 10, 700, 0, 1'b0, 1'b0, 1'b0, 8, 2, 3, 1, 1'b0);
        // R8: force max
        run_case("R8 force", 2047, 2047, 2047, 3, 1'b1, 1'b1, 1'b1, 15, 15, 15, 15, 1'b0);
        // R9: code 0 fails too
        run_case("R9 error", 2047, 2047, 2047, 3, 1'b0, 1'b0, 1'b0, 15, 15, 1, 1, 1'b0);

        // R11: start during search ignored
        run_case("R11 restart ignored", 700, 350, 900, 0, 1'b0, 1'b1, 1'b0, 15, 12, 6, 8, 1'b1);
        extra_done = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done_o) extra_done++;
        end
        check("R11 no extra done", extra_done, 0);
        // R10: result held while idle
        check("R10 cfg held", int'(cfg_o), 3);

        // R7: sweep of the candidate search
        for (int w = 0; w < 6; w++)
            for (int t = 0; t < 4; t++)
                for (int d = 0; d < 4; d++)
                    for (int m = 0; m < 4; m++)
                        run_case("R7 sweep", sw_y[w], sw_c[w], sw_o[w], d, m[0], m[1], 1'b0,
                                 st_y[t], st_c[t], sr_y[t], sr_c[t], 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule